// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 14-bit virtual address from the processor into a 12-bit physical address. Pages are 64 bytes, so the low six address bits pass through unchanged and only the 8-bit virtual page number is translated to a 6-bit physical page number. Recent translations are kept in a 16-entry translation cache. It has 4 sets of 4 ways. The set is chosen by the two low bits of the virtual page number, and the remaining six bits form the tag. A hit produces the physical address without touching memory. A miss makes the block read one page-table entry from memory, at the table base register plus the virtual page number. It then checks the entry and, if the entry is usable, installs it in the cache.

Every access is checked against the entry's present bit and its read, write and execute permissions. A failed check raises a fault with a cause code instead of a physical address. Only one translation is in flight at a time. The controller has four states:
- `ST_IDLE`: ready for a request. Accepting a request moves to `ST_LOOKUP`.
- `ST_LOOKUP`: probes the cache. A hit finishes the translation and returns to `ST_IDLE`. A miss moves to `ST_WALK_REQ`.
- `ST_WALK_REQ`: holds the table read request until memory accepts it, then moves to `ST_WALK_WAIT`.
- `ST_WALK_WAIT`: waits for the entry to arrive, checks it, finishes the translation and returns to `ST_IDLE`.

Page-table entry layout:
- bits 5:0 hold the physical page number;
- bit 6 is present;
- bit 7 allows read;
- bit 8 allows write;
- bit 9 allows execute.

Access kind encoding: 0 is read, 1 is write, 2 is instruction fetch, and 3 is treated as a fetch. Fault cause encoding: 0 is not present, 1 is read denied, 2 is write denied, 3 is execute denied.

Top module: `mmu_xlate`

## Requirements
- R1: A successful translation returns physical address {physical page number, virtual address bits 5:0}. For example, VA 0x03D4 mapped to page 0x0D gives 0x354, and VA 0x0020 mapped to page 0x28 gives 0xA20.
- R2: A translation whose page is cached (set = VPN bits 1:0, tag = VPN bits 7:2) completes with no page-table read.
- R3: On a miss the block issues exactly one page-table read, at address base + VPN. It holds the request valid, with a stable address, until `pt_rd_ready` is seen.
- R4: A fetched entry with its present bit (bit 6) clear produces a fault with cause 0 and no physical address.
- R5: A read needs bit 7, a write needs bit 8 and a fetch needs bit 9, whether the entry comes from the cache or from memory. A violation faults with cause 1, 2 or 3 respectively.
- R6: An entry that produced any fault is not installed, so a repeat of the access walks the table again.
- R7: A fill goes to the lowest-numbered invalid way of its set. When the set is full, a per-set round-robin pointer (starting at way 0, advancing only on replacement) selects the victim.
- R8: Writing the table base register invalidates every cached entry in that cycle. Later walks use the new base.
- R9: `req_ready` is high only in the idle state. A request presented while busy has no effect.
- R10: Each accepted request yields exactly one single-cycle result: either `rsp_valid` or `flt_valid`, never both.
- R11: If the base register is written while a translation is in flight, that translation completes from the entry already requested, but its entry is not installed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | High when a request can be accepted |
| req_vaddr | input | 14 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| rsp_valid | output | 1 | One-cycle strobe for a successful translation |
| rsp_paddr | output | 12 | Physical address |
| flt_valid | output | 1 | One-cycle fault strobe |
| flt_cause | output | 2 | Fault cause: 0 absent, 1 read, 2 write, 3 execute |
| ptb_we | input | 1 | Table base register write enable |
| ptb_wdata | input | 12 | New table base |
| pt_rd_valid | output | 1 | Page-table read request |
| pt_rd_ready | input | 1 | Memory accepts the read |
| pt_rd_addr | output | 12 | Page-table entry address |
| pt_rsp_valid | input | 1 | Entry data strobe |
| pt_rsp_data | input | 10 | Page-table entry |

## Verification
The hardest situation to reach is a base-register write that lands while a walk is waiting on memory. The in-flight result must still come from the old table, but it must not leave a cache entry behind.

The bench's memory model stretches its response latency to six cycles, and a parallel thread writes the base register during that window. A repeat of the same address is then expected to walk at the new base, which yields a different page.

Replacement order is reached by filling one set with five distinct tags, then probing which of them still hit. Hits and misses are told apart by counting page-table reads.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        FLT_ABSENT = 2'd0,
        FLT_READ   = 2'd1,
        FLT_WRITE  = 2'd2,
        FLT_EXEC   = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WALK_REQ,
        ST_WALK_WAIT
    } state_e;

    // permission vector order inside the block: bit0 read, bit1 write, bit2 execute
    localparam int PERM_W = 3;

endpackage

// File: rtl/mmu_perm.sv
module mmu_perm
    import mmu_pkg::*;
(
    input  logic              present,
    input  logic [1:0]        kind,
    input  logic [PERM_W-1:0] perm,
    output logic              fault,
    output cause_e            cause
);

    always_comb begin
        fault = 1'b0;
        cause = FLT_ABSENT;
        if (!present) begin
            fault = 1'b1;
        end else begin
            unique case (kind)
                ACC_READ: begin
                    if (!perm[0]) begin
                        fault = 1'b1;
                        cause = FLT_READ;
                    end
                end
                ACC_WRITE: begin
                    if (!perm[1]) begin
                        fault = 1'b1;
                        cause = FLT_WRITE;
                    end
                end
                default: begin
                    if (!perm[2]) begin
                        fault = 1'b1;
                        cause = FLT_EXEC;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb
    import mmu_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int PPN_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [$clog2(SETS)-1:0]  lk_idx,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic                     hit,
    output logic [PPN_W-1:0]         hit_ppn,
    output logic [PERM_W-1:0]        hit_perm,
    input  logic                     fill_en,
    input  logic [$clog2(SETS)-1:0]  fill_idx,
    input  logic [TAG_W-1:0]         fill_tag,
    input  logic [PPN_W-1:0]         fill_ppn,
    input  logic [PERM_W-1:0]        fill_perm
);

    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [SETS-1:0]              set_hit;
    logic [SETS-1:0][PPN_W-1:0]   set_ppn;
    logic [SETS-1:0][PERM_W-1:0]  set_perm;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [WAYS-1:0]     vld_q;
        logic [TAG_W-1:0]    tag_q  [WAYS];
        logic [PPN_W-1:0]    ppn_q  [WAYS];
        logic [PERM_W-1:0]   perm_q [WAYS];
        logic [WAY_W-1:0]    rr_q;
        logic [WAY_W-1:0]    vic;
        logic                wr;
        logic                h;
        logic [PPN_W-1:0]    p;
        logic [PERM_W-1:0]   pm;

        assign wr = fill_en && !flush && (fill_idx == IDX_W'(s));

        // lowest invalid way, else the round-robin pointer
        always_comb begin
            vic = rr_q;
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!vld_q[w]) vic = WAY_W'(w);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= '0;
                rr_q  <= '0;
            end else if (flush) begin
                vld_q <= '0;
            end else if (wr) begin
                vld_q[vic] <= 1'b1;
                if (&vld_q) begin
                    rr_q <= (rr_q == WAY_W'(WAYS - 1)) ? '0 : rr_q + 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (wr) begin
                tag_q[vic]  <= fill_tag;
                ppn_q[vic]  <= fill_ppn;
                perm_q[vic] <= fill_perm;
            end
        end

        always_comb begin
            h  = 1'b0;
            p  = '0;
            pm = '0;
            for (int w = 0; w < WAYS; w++) begin
                if (vld_q[w] && (tag_q[w] == lk_tag)) begin
                    h  = 1'b1;
                    p  = ppn_q[w];
                    pm = perm_q[w];
                end
            end
        end

        assign set_hit[s]  = h;
        assign set_ppn[s]  = p;
        assign set_perm[s] = pm;
    end

    assign hit      = set_hit[lk_idx];
    assign hit_ppn  = set_ppn[lk_idx];
    assign hit_perm = set_perm[lk_idx];

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
#(
    parameter int VA_W       = 14,
    parameter int PA_W       = 12,
    parameter int PAGE_BYTES = 64,
    parameter int TLB_SETS   = 4,
    parameter int TLB_WAYS   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [VA_W-1:0]          req_vaddr,
    input  logic [1:0]               req_kind,
    output logic                     rsp_valid,
    output logic [PA_W-1:0]          rsp_paddr,
    output logic                     flt_valid,
    output logic [1:0]               flt_cause,
    input  logic                     ptb_we,
    input  logic [PA_W-1:0]          ptb_wdata,
    output logic                     pt_rd_valid,
    input  logic                     pt_rd_ready,
    output logic [PA_W-1:0]          pt_rd_addr,
    input  logic                     pt_rsp_valid,
    input  logic [PA_W-$clog2(PAGE_BYTES)+3:0] pt_rsp_data
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = $clog2(TLB_SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int PTE_W = PPN_W + 4;

    state_e              state_q, state_d;
    logic [VA_W-1:0]     va_q;
    logic [1:0]          kind_q;
    logic [PA_W-1:0]     base_q;
    logic [PA_W-1:0]     walk_addr_q;
    logic                drop_q;

    logic [VPN_W-1:0]    vpn;
    logic [IDX_W-1:0]    idx;
    logic [TAG_W-1:0]    tag;

    logic                tlb_hit;
    logic [PPN_W-1:0]    tlb_ppn;
    logic [PERM_W-1:0]   tlb_perm;

    logic [PPN_W-1:0]    pte_ppn;
    logic                pte_present;
    logic [PERM_W-1:0]   pte_perm;

    logic                in_lookup;
    logic                chk_present;
    logic [PERM_W-1:0]   chk_perm;
    logic [PPN_W-1:0]    sel_ppn;
    logic                chk_fault;
    cause_e              chk_cause;
    logic                fill_en;
    logic                accept;
    logic                finish;

    assign vpn = va_q[VA_W-1:OFF_W];
    assign idx = vpn[IDX_W-1:0];
    assign tag = vpn[VPN_W-1:IDX_W];

    assign pte_ppn     = pt_rsp_data[PPN_W-1:0];
    assign pte_present = pt_rsp_data[PPN_W];
    assign pte_perm    = pt_rsp_data[PTE_W-1:PPN_W+1];

    assign in_lookup   = (state_q == ST_LOOKUP);
    assign chk_present = in_lookup ? 1'b1     : pte_present;
    assign chk_perm    = in_lookup ? tlb_perm : pte_perm;
    assign sel_ppn     = in_lookup ? tlb_ppn  : pte_ppn;

    assign accept = req_valid && (state_q == ST_IDLE);
    assign finish = (in_lookup && tlb_hit) ||
                    ((state_q == ST_WALK_WAIT) && pt_rsp_valid);
    assign fill_en = (state_q == ST_WALK_WAIT) && pt_rsp_valid &&
                     !chk_fault && !drop_q && !ptb_we;

    mmu_tlb #(
        .SETS  (TLB_SETS),
        .WAYS  (TLB_WAYS),
        .TAG_W (TAG_W),
        .PPN_W (PPN_W)
    ) u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (ptb_we),
        .lk_idx    (idx),
        .lk_tag    (tag),
        .hit       (tlb_hit),
        .hit_ppn   (tlb_ppn),
        .hit_perm  (tlb_perm),
        .fill_en   (fill_en),
        .fill_idx  (idx),
        .fill_tag  (tag),
        .fill_ppn  (pte_ppn),
        .fill_perm (pte_perm)
    );

    mmu_perm u_perm (
        .present (chk_present),
        .kind    (kind_q),
        .perm    (chk_perm),
        .fault   (chk_fault),
        .cause   (chk_cause)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid)    state_d = ST_LOOKUP;
            ST_LOOKUP:    state_d = tlb_hit ? ST_IDLE : ST_WALK_REQ;
            ST_WALK_REQ:  if (pt_rd_ready)  state_d = ST_WALK_WAIT;
            ST_WALK_WAIT: if (pt_rsp_valid) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_paddr   <= '0;
            flt_valid   <= 1'b0;
            flt_cause   <= '0;
            va_q        <= '0;
            kind_q      <= '0;
            base_q      <= '0;
            walk_addr_q <= '0;
            drop_q      <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            flt_valid <= 1'b0;
            if (accept) begin
                va_q   <= req_vaddr;
                kind_q <= req_kind;
                drop_q <= 1'b0;
            end
            if (in_lookup) begin
                walk_addr_q <= base_q + PA_W'(vpn);
            end
            if (finish) begin
                if (chk_fault) begin
                    flt_valid <= 1'b1;
                    flt_cause <= chk_cause;
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_paddr <= {sel_ppn, va_q[OFF_W-1:0]};
                end
            end
            if (ptb_we) begin
                base_q <= ptb_wdata;
                if (state_q != ST_IDLE) drop_q <= 1'b1;
            end
        end
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign pt_rd_valid = (state_q == ST_WALK_REQ);
    assign pt_rd_addr  = walk_addr_q;

endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk #(
    parameter int PA_W  = 12,
    parameter int OFF_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             flt_valid,
    input logic             pt_rd_valid,
    input logic             pt_rd_ready,
    input logic [PA_W-1:0]  pt_rd_addr,
    input logic [OFF_W-1:0] va_off,
    input logic             fill_en
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && flt_valid)); // R10

    AST_OUTCOME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || flt_valid) |=> !(rsp_valid || flt_valid)); // R10

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_paddr[OFF_W-1:0] == va_off)); // R1

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_valid |-> !req_ready); // R9

    AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_rd_valid && !pt_rd_ready) |=> (pt_rd_valid && $stable(pt_rd_addr))); // R3

    AST_NO_FAULT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> !$past(fill_en)); // R6

endmodule

bind mmu_xlate mmu_xlate_chk #(
    .PA_W  (PA_W),
    .OFF_W (OFF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_paddr   (rsp_paddr),
    .flt_valid   (flt_valid),
    .pt_rd_valid (pt_rd_valid),
    .pt_rd_ready (pt_rd_ready),
    .pt_rd_addr  (pt_rd_addr),
    .va_off      (va_q[OFF_W-1:0]),
    .fill_en     (fill_en)
);

// File: tb/mmu_xlate_tb_top.sv
`timescale 1ns/1ps
module mmu_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [11:0] rsp_paddr;
    logic        flt_valid;
    logic [1:0]  flt_cause;
    logic        ptb_we = 1'b0;
    logic [11:0] ptb_wdata = '0;
    logic        pt_rd_valid;
    logic        pt_rd_ready = 1'b0;
    logic [11:0] pt_rd_addr;
    logic        pt_rsp_valid = 1'b0;
    logic [9:0]  pt_rsp_data = '0;

    always #2.5 clk = ~clk;

    mmu_xlate dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .req_kind     (req_kind),
        .rsp_valid    (rsp_valid),
        .rsp_paddr    (rsp_paddr),
        .flt_valid    (flt_valid),
        .flt_cause    (flt_cause),
        .ptb_we       (ptb_we),
        .ptb_wdata    (ptb_wdata),
        .pt_rd_valid  (pt_rd_valid),
        .pt_rd_ready  (pt_rd_ready),
        .pt_rd_addr   (pt_rd_addr),
        .pt_rsp_valid (pt_rsp_valid),
        .pt_rsp_data  (pt_rsp_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int rsp_lat = 0;

    // ---------------- page-table memory model ----------------
    logic [9:0]  mem [4096];
    logic [11:0] mem_addr_l;
    bit          pend = 0;
    int          pend_cnt = 0;

    always @(negedge clk) begin
        if (pt_rsp_valid) pt_rsp_valid = 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                pt_rsp_valid = 1'b1;
                pt_rsp_data  = mem[mem_addr_l];
                pend = 0;
            end else begin
                pend_cnt--;
            end
        end
        if (pt_rd_ready) begin
            pt_rd_ready = 1'b0;
            rd_cnt++;
            pend = 1;
            pend_cnt = rsp_lat;
        end else if (pt_rd_valid && !pend) begin
            pt_rd_ready = 1'b1;
            mem_addr_l  = pt_rd_addr;
        end
    end

    // entry: {x,w,r,present,ppn[5:0]}
    task automatic put_pte(input int base, input int vpn, input int ppn,
                           input bit v, input bit r, input bit w, input bit x);
        mem[(base + vpn) & 12'hFFF] = {x, w, r, v, 6'(ppn)};
    endtask

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          is_flt;
        logic [11:0] pa;
        logic [1:0]  cause;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_e;

    always @(negedge clk) begin
        if (rst_n && (rsp_valid || flt_valid)) begin
            n_chk++;
            if (sbq.size() == 0) begin
                n_bad++;
                $display("FAIL R10 unexpected result: rsp=%0b flt=%0b expected none",
                         rsp_valid, flt_valid);
            end else begin
                mon_e = sbq.pop_front();
                if (mon_e.is_flt) begin
                    if (!(flt_valid && !rsp_valid && flt_cause == mon_e.cause)) begin
                        n_bad++;
                        $display("FAIL %s fault: flt=%0b rsp=%0b cause=%0d expected fault cause=%0d",
                                 mon_e.tag, flt_valid, rsp_valid, flt_cause, mon_e.cause);
                    end
                end else begin
                    if (!(rsp_valid && !flt_valid && rsp_paddr == mon_e.pa)) begin
                        n_bad++;
                        $display("FAIL %s translate: rsp=%0b flt=%0b pa=%h expected pa=%h",
                                 mon_e.tag, rsp_valid, flt_valid, rsp_paddr, mon_e.pa);
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] pa_of(input int ppn, input logic [13:0] va);
        return {6'(ppn), va[5:0]};
    endfunction

    // driver: push expectation, present request, wait for the result
    task automatic xlate(input logic [13:0] va, input logic [1:0] kind,
                         input bit is_flt, input logic [11:0] pa,
                         input logic [1:0] cause, input int exp_rd, input string tag);
        exp_t e;
        int   r0;
        r0 = rd_cnt;
        e.is_flt = is_flt;
        e.pa     = pa;
        e.cause  = cause;
        e.tag    = tag;
        sbq.push_back(e);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_kind  = kind;
        @(negedge clk);
        req_valid = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
        check((rd_cnt - r0) == exp_rd, {tag, " table reads"}, rd_cnt - r0, exp_rd);
    endtask

    task automatic set_base(input logic [11:0] b);
        @(negedge clk);
        ptb_we    = 1'b1;
        ptb_wdata = b;
        @(negedge clk);
        ptb_we    = 1'b0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        // table at 0x100
        put_pte(12'h100, 8'h0F, 6'h0D, 1, 1, 1, 0);
        put_pte(12'h100, 8'h00, 6'h28, 1, 1, 0, 0);
        put_pte(12'h100, 8'h2E, 6'h3F, 0, 1, 1, 1);
        put_pte(12'h100, 8'h04, 6'h11, 1, 0, 0, 1);
        for (int v = 1; v <= 17; v += 4) put_pte(12'h100, v, (v + 16) & 63, 1, 1, 0, 0);
        // table at 0x200 and 0x300
        put_pte(12'h200, 8'h0F, 6'h22, 1, 1, 0, 0);
        put_pte(12'h200, 8'h00, 6'h30, 1, 1, 0, 0);
        put_pte(12'h300, 8'h00, 6'h31, 1, 1, 0, 0);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
        check(!rsp_valid && !flt_valid, "R10 reset outputs quiet", {rsp_valid, flt_valid}, 0);
        check(pt_rd_valid == 1'b0, "R3 reset no read", pt_rd_valid, 0);

        set_base(12'h100);

        // R1 / R3: misses, then R2 hits
        xlate(14'h03D4, 2'd0, 0, 12'h354, 0, 1, "R1_R3 miss 0x03D4");
        xlate(14'h03D4, 2'd0, 0, 12'h354, 0, 0, "R2 hit 0x03D4");
        xlate(14'h03C0, 2'd1, 0, 12'h340, 0, 0, "R2_R5 write hit 0x03C0");
        xlate(14'h03D4, 2'd2, 1, 0, 2'd3, 0, "R5 fetch exec denied on hit");
        xlate(14'h0020, 2'd0, 0, 12'hA20, 0, 1, "R1_R3 miss 0x0020");
        xlate(14'h0020, 2'd1, 1, 0, 2'd2, 0, "R5 write denied on hit");

        // R4 / R6: absent entry is never cached
        xlate(14'h0B8F, 2'd0, 1, 0, 2'd0, 1, "R4 absent entry");
        xlate(14'h0B8F, 2'd0, 1, 0, 2'd0, 1, "R6 absent entry walks again");

        // R5 / R6: execute-only page
        xlate(14'h0105, 2'd0, 1, 0, 2'd1, 1, "R5 read denied from walk");
        xlate(14'h0105, 2'd0, 1, 0, 2'd1, 1, "R6 denied entry walks again");
        xlate(14'h0105, 2'd2, 0, pa_of(6'h11, 14'h0105), 0, 1, "R5 fetch allowed");
        xlate(14'h0105, 2'd2, 0, pa_of(6'h11, 14'h0105), 0, 0, "R2 fetch hit");

        // R7: replacement in set 1 (VPNs 0x01,0x05,0x09,0x0D,0x11)
        for (int v = 1; v <= 13; v += 4)
            xlate(14'(v << 6), 2'd0, 0, pa_of(v + 16, 14'(v << 6)), 0, 1, "R7 fill empty way");
        for (int v = 1; v <= 13; v += 4)
            xlate(14'(v << 6), 2'd0, 0, pa_of(v + 16, 14'(v << 6)), 0, 0, "R7 all four resident");
        xlate(14'(17 << 6), 2'd0, 0, pa_of(33, 14'(17 << 6)), 0, 1, "R7 fifth tag evicts way0");
        xlate(14'(5 << 6),  2'd0, 0, pa_of(21, 14'(5 << 6)),  0, 0, "R7 way1 still resident");
        xlate(14'(1 << 6),  2'd0, 0, pa_of(17, 14'(1 << 6)),  0, 1, "R7 evicted tag misses");
        xlate(14'(9 << 6),  2'd0, 0, pa_of(25, 14'(9 << 6)),  0, 0, "R7 way2 still resident");
        xlate(14'(5 << 6),  2'd0, 0, pa_of(21, 14'(5 << 6)),  0, 1, "R7 round robin took way1");

        // R8: base write flushes and redirects walks
        set_base(12'h200);
        xlate(14'h03D4, 2'd0, 0, pa_of(6'h22, 14'h03D4), 0, 1, "R8 flushed, new base");

        // R11 / R9: base write during an outstanding walk
        rsp_lat = 6;
        fork
            xlate(14'h0020, 2'd0, 0, 12'hC20, 0, 1, "R11 in-flight walk uses old entry");
            begin
                repeat (3) @(negedge clk);
                check(req_ready == 1'b0, "R9 busy not ready", req_ready, 0);
                req_valid = 1'b1;
                req_vaddr = 14'h03D4;
                req_kind  = 2'd2;
                @(negedge clk);
                ptb_we    = 1'b1;
                ptb_wdata = 12'h300;
                @(negedge clk);
                ptb_we    = 1'b0;
                req_valid = 1'b0;
            end
        join
        rsp_lat = 0;
        repeat (4) @(negedge clk);
        check(sbq.size() == 0 && req_ready, "R9 busy request ignored", sbq.size(), 0);
        xlate(14'h0020, 2'd0, 0, 12'hC60, 0, 1, "R11 dropped fill walks at new base");
        xlate(14'h0020, 2'd0, 0, 12'hC60, 0, 0, "R2 later fill cached");

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog expired: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule